// File: doc/BRIEF.md
# Configurable Bridge Gate Sequencer

This block is the clocked decision logic behind a four-gate power stage: a high-side and a low-side switch on each of two legs, leg A and leg B. One shared set of control inputs is read in one of two ways, picked by a mode input. In full-bridge mode the two legs form one H-bridge. A direction input picks which diagonal conducts, and a PWM input gates that diagonal, so both sign/magnitude drive and anti-phase drive are possible. A slow-decay select sets whether only the low-side switch follows PWM or both switches of the diagonal do. A brake input shorts the load through both low-side switches. In dual-leg mode each leg follows its own level input and has its own enable.

Force-off conditions override in a fixed order. An undervoltage flag ranks highest, then enable low, then the overcurrent inhibits, then brake, then normal decoding. Each leg has its own dead-time sequencer. A gate turns off one clock edge after it is requested off. A gate turns on only after the opposite switch of the same leg has stayed off for a programmable number of cycles. All inputs are expected to be synchronous to the clock already.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: While reset is asserted, all four gate outputs are low, whatever the inputs are.
- R2: In full-bridge mode (mode_hb=1), with no force-off active, slow_dec=0 and pwm_enb=1, dir_ina=1 drives top A and bottom B on with the other two gates off. dir_ina=0 drives top B and bottom A on with the other two off.
- R3: In full-bridge mode with slow_dec=0, pwm_enb=0 turns all gates off. With pwm_enb held at 1, toggling dir_ina swaps between the two diagonals (anti-phase drive).
- R4: In full-bridge mode with slow_dec=1, the top gate of the selected diagonal stays on whatever pwm_enb is, and only the bottom gate of that diagonal follows pwm_enb.
- R5: In full-bridge mode with brake=1, enable high and no undervoltage or overcurrent, both bottom gates are on and both top gates are off. This holds regardless of dir_ina, pwm_enb and slow_dec.
- R6: In full-bridge mode, en_ena=0 turns every gate off, and it takes priority over brake.
- R7: In dual-leg mode (mode_hb=0), leg A follows dir_ina and is enabled by en_ena. Leg B follows slow_dec and is enabled by pwm_enb. A level of 1 turns that leg's top gate on and 0 turns its bottom gate on. Disabling one leg turns off only that leg.
- R8: In dual-leg mode, brake has no effect on any gate.
- R9: uv_flag=1 turns all four gates off in both modes, above every other input.
- R10: In full-bridge mode, oc_a or oc_b turns all gates off, and it takes priority over brake. In dual-leg mode, oc_a turns off only leg A and oc_b turns off only leg B.
- R11: The top and bottom gates of the same leg are never on in the same cycle.
- R12: A gate drops one clock edge after its request is withdrawn. A gate that is requested on rises on the (DEAD_CYC+1)th edge after the opposite gate of its leg went low. Between the two, the leg shows exactly DEAD_CYC+1 sampled cycles with both gates off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_hb | input | 1 | 1 = full H-bridge, 0 = two independent legs |
| dir_ina | input | 1 | Direction (full bridge) or leg A level (dual) |
| pwm_enb | input | 1 | PWM (full bridge) or leg B enable (dual) |
| en_ena | input | 1 | Global enable (full bridge) or leg A enable (dual) |
| slow_dec | input | 1 | Slow-decay select (full bridge) or leg B level (dual); the board keeps it high when undriven |
| brake | input | 1 | Low-side brake request, full-bridge mode only |
| uv_flag | input | 1 | Undervoltage force-off |
| oc_a | input | 1 | Overcurrent inhibit, leg A |
| oc_b | input | 1 | Overcurrent inhibit, leg B |
| gate_top_a | output | 1 | High-side gate command, leg A |
| gate_bot_a | output | 1 | Low-side gate command, leg A |
| gate_top_b | output | 1 | High-side gate command, leg B |
| gate_bot_b | output | 1 | Low-side gate command, leg B |

## Verification
The hardest case to reach is a direct hand-over within one leg. The gate that is on must drop while its partner is already requested on, and the partner must then wait out the whole dead-time count. The bench sets this up in dual-leg mode. It holds leg A high until the top gate has settled on, then flips the level on a falling clock edge. From then on it samples every cycle, confirming the top gate drops after one edge and counting the both-off cycles until the bottom gate rises. The same hand-over happens in the anti-phase sequence, where each direction flip moves both legs at once.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

   localparam int unsigned NUM_LEGS = 2;
   localparam int unsigned LEG_A    = 0;
   localparam int unsigned LEG_B    = 1;

   typedef struct packed {
      logic top;
      logic bot;
   } leg_req_t;

endpackage

// File: rtl/bgc_decode.sv
module bgc_decode
   import bgc_pkg::*;
(
   input  logic                      mode_hb,
   input  logic                      dir_ina,
   input  logic                      pwm_enb,
   input  logic                      en_ena,
   input  logic                      slow_dec,
   input  logic                      brake,
   input  logic                      uv_flag,
   input  logic                      oc_a,
   input  logic                      oc_b,
   output leg_req_t [NUM_LEGS-1:0]   req
);

   logic [NUM_LEGS-1:0] leg_en;
   logic [NUM_LEGS-1:0] leg_lvl;
   logic [NUM_LEGS-1:0] leg_oc;
   logic                hb_kill;
   logic                diag_top;

   assign leg_en[LEG_A]  = en_ena;
   assign leg_en[LEG_B]  = pwm_enb;
   assign leg_lvl[LEG_A] = dir_ina;
   assign leg_lvl[LEG_B] = slow_dec;
   assign leg_oc[LEG_A]  = oc_a;
   assign leg_oc[LEG_B]  = oc_b;

   // Priority in full-bridge mode: undervoltage, enable, overcurrent, brake
   assign hb_kill  = uv_flag | ~en_ena | oc_a | oc_b;
   // In slow decay the top of the active diagonal is held on
   assign diag_top = slow_dec | pwm_enb;

   always_comb begin
      req = '0;
      if (mode_hb) begin
         if (hb_kill) begin
            req = '0;
         end else if (brake) begin
            req[LEG_A].bot = 1'b1;
            req[LEG_B].bot = 1'b1;
         end else if (dir_ina) begin
            req[LEG_A].top = diag_top;
            req[LEG_B].bot = pwm_enb;
         end else begin
            req[LEG_B].top = diag_top;
            req[LEG_A].bot = pwm_enb;
         end
      end else begin
         for (int h = 0; h < NUM_LEGS; h++) begin
            if (!uv_flag && leg_en[h] && !leg_oc[h]) begin
               req[h].top = leg_lvl[h];
               req[h].bot = ~leg_lvl[h];
            end
         end
      end
   end

endmodule

// File: rtl/bgc_deadtime.sv
module bgc_deadtime
   import bgc_pkg::*;
#(
   parameter int unsigned DEAD_CYC = 63
) (
   input  logic     clk,
   input  logic     rst_n,
   input  leg_req_t req,
   output logic     top_q,
   output logic     bot_q
);

   localparam int unsigned CW = $clog2(DEAD_CYC + 2);
   localparam logic [CW-1:0] DT_MAX = CW'(DEAD_CYC);

   generate
      if (DEAD_CYC < 1) begin : g_bad_dt
         $error("bgc_deadtime: DEAD_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] top_off_cnt;
   logic [CW-1:0] bot_off_cnt;
   logic          top_ok;
   logic          bot_ok;

   assign top_ok = (bot_off_cnt == DT_MAX) && !bot_q;
   assign bot_ok = (top_off_cnt == DT_MAX) && !top_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q       <= 1'b0;
         bot_q       <= 1'b0;
         top_off_cnt <= '0;
         bot_off_cnt <= '0;
      end else begin
         top_q <= req.top && top_ok;
         bot_q <= req.bot && bot_ok;
         if (top_q)                    top_off_cnt <= '0;
         else if (top_off_cnt != DT_MAX) top_off_cnt <= top_off_cnt + 1'b1;
         if (bot_q)                    bot_off_cnt <= '0;
         else if (bot_off_cnt != DT_MAX) bot_off_cnt <= bot_off_cnt + 1'b1;
      end
   end

   // Independent watch counters for the dead-time property
   logic [CW:0] w_top_low;
   logic [CW:0] w_bot_low;
   localparam logic [CW:0] W_SAT = (CW+1)'(DEAD_CYC + 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_top_low <= '0;
         w_bot_low <= '0;
      end else begin
         w_top_low <= top_q ? '0 : ((w_top_low == W_SAT) ? W_SAT : w_top_low + 1'b1);
         w_bot_low <= bot_q ? '0 : ((w_bot_low == W_SAT) ? W_SAT : w_bot_low + 1'b1);
      end
   end

   p_no_shoot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(top_q && bot_q));

   p_gap_bot_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bot_q) |-> (w_top_low >= (CW+1)'(DEAD_CYC)));

   p_gap_top_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(top_q) |-> (w_bot_low >= (CW+1)'(DEAD_CYC)));

endmodule

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl
   import bgc_pkg::*;
#(
   parameter int unsigned DEAD_CYC = 63
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_hb,
   input  logic dir_ina,
   input  logic pwm_enb,
   input  logic en_ena,
   input  logic slow_dec,
   input  logic brake,
   input  logic uv_flag,
   input  logic oc_a,
   input  logic oc_b,
   output logic gate_top_a,
   output logic gate_bot_a,
   output logic gate_top_b,
   output logic gate_bot_b
);

   leg_req_t [NUM_LEGS-1:0] req;
   logic     [NUM_LEGS-1:0] top_q;
   logic     [NUM_LEGS-1:0] bot_q;

   bgc_decode u_decode (
      .mode_hb  (mode_hb),
      .dir_ina  (dir_ina),
      .pwm_enb  (pwm_enb),
      .en_ena   (en_ena),
      .slow_dec (slow_dec),
      .brake    (brake),
      .uv_flag  (uv_flag),
      .oc_a     (oc_a),
      .oc_b     (oc_b),
      .req      (req)
   );

   generate
      for (genvar h = 0; h < NUM_LEGS; h++) begin : g_leg
         bgc_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req[h]),
            .top_q (top_q[h]),
            .bot_q (bot_q[h])
         );
      end
   endgenerate

   assign gate_top_a = top_q[LEG_A];
   assign gate_bot_a = bot_q[LEG_A];
   assign gate_top_b = top_q[LEG_B];
   assign gate_bot_b = bot_q[LEG_B];

   logic any_gate;
   assign any_gate = gate_top_a | gate_bot_a | gate_top_b | gate_bot_b;

   p_uv_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      uv_flag |=> !any_gate);

   p_en_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_hb && !en_ena) |=> !any_gate);

   p_hb_oc_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_hb && (oc_a || oc_b)) |=> !any_gate);

   p_leg_oc_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_hb && oc_a) |=> !(gate_top_a || gate_bot_a));

   p_leg_oc_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_hb && oc_b) |=> !(gate_top_b || gate_bot_b));

   p_brake_tops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_hb && brake) |=> !(gate_top_a || gate_top_b));

endmodule

// File: tb/sim_bridge_gate_ctrl.sv
`timescale 1ns/1ps
module sim_bridge_gate_ctrl;

   localparam int unsigned DT = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_hb = 1'b1, dir_ina = 1'b0, pwm_enb = 1'b0, en_ena = 1'b0;
   logic slow_dec = 1'b1, brake = 1'b0, uv_flag = 1'b0, oc_a = 1'b0, oc_b = 1'b0;
   logic gate_top_a, gate_bot_a, gate_top_b, gate_bot_b;

   int n_checks = 0;
   int n_fail   = 0;
   int shoot    = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   bridge_gate_ctrl #(.DEAD_CYC(DT)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_hb(mode_hb), .dir_ina(dir_ina),
      .pwm_enb(pwm_enb), .en_ena(en_ena), .slow_dec(slow_dec), .brake(brake),
      .uv_flag(uv_flag), .oc_a(oc_a), .oc_b(oc_b),
      .gate_top_a(gate_top_a), .gate_bot_a(gate_bot_a),
      .gate_top_b(gate_top_b), .gate_bot_b(gate_bot_b)
   );

   always @(negedge clk)
      if (rst_n && ((gate_top_a && gate_bot_a) || (gate_top_b && gate_bot_b)))
         shoot++;

   function automatic logic [3:0] gates();
      return {gate_top_a, gate_bot_a, gate_top_b, gate_bot_b};
   endfunction

   task automatic check(string req, logic [3:0] exp);
      n_checks++;
      if (gates() !== exp) begin
         n_fail++;
         $display("FAIL %s: gates {ta,ba,tb,bb} = %b expected %b", req, gates(), exp);
      end
   endtask

   task automatic check_int(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (DT + 4) @(negedge clk);
   endtask

   task automatic hb_set(logic d, logic p, logic q, logic b, logic e);
      @(negedge clk);
      mode_hb = 1'b1; dir_ina = d; pwm_enb = p; slow_dec = q; brake = b; en_ena = e;
      settle();
   endtask

   task automatic t_reset();
      mode_hb = 1'b0; en_ena = 1'b1; pwm_enb = 1'b1; dir_ina = 1'b1; slow_dec = 1'b0;
      repeat (DT + 4) @(negedge clk);
      check("R1 reset", 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_diag();
      hb_set(1, 1, 0, 0, 1); check("R2 dir=1", 4'b1001);
      hb_set(0, 1, 0, 0, 1); check("R2 dir=0", 4'b0110);
   endtask

   task automatic t_pwm_antiphase();
      hb_set(1, 0, 0, 0, 1); check("R3 pwm=0 qs=0", 4'b0000);
      hb_set(1, 1, 0, 0, 1); check("R3 antiphase d1", 4'b1001);
      hb_set(0, 1, 0, 0, 1); check("R3 antiphase d0", 4'b0110);
      hb_set(1, 1, 0, 0, 1); check("R3 antiphase d1 again", 4'b1001);
   endtask

   task automatic t_slow();
      hb_set(1, 0, 1, 0, 1); check("R4 qs=1 dir=1 pwm=0", 4'b1000);
      hb_set(1, 1, 1, 0, 1); check("R4 qs=1 dir=1 pwm=1", 4'b1001);
      hb_set(0, 0, 1, 0, 1); check("R4 qs=1 dir=0 pwm=0", 4'b0010);
   endtask

   task automatic t_brake();
      hb_set(1, 1, 0, 1, 1); check("R5 brake dir=1", 4'b0101);
      hb_set(0, 0, 1, 1, 1); check("R5 brake dir=0 qs=1", 4'b0101);
   endtask

   task automatic t_enable();
      hb_set(1, 1, 0, 0, 0); check("R6 en low", 4'b0000);
      hb_set(1, 1, 0, 1, 0); check("R6 en low over brake", 4'b0000);
   endtask

   task automatic t_legs();
      @(negedge clk);
      mode_hb = 1'b0; brake = 1'b0; en_ena = 1'b1; pwm_enb = 1'b1;
      dir_ina = 1'b1; slow_dec = 1'b0;
      settle(); check("R7 A hi B lo", 4'b1001);
      @(negedge clk); dir_ina = 1'b0; slow_dec = 1'b1;
      settle(); check("R7 A lo B hi", 4'b0110);
      @(negedge clk); en_ena = 1'b0;
      settle(); check("R7 leg A disabled", 4'b0010);
      @(negedge clk); en_ena = 1'b1; pwm_enb = 1'b0;
      settle(); check("R7 leg B disabled", 4'b0100);
      @(negedge clk); pwm_enb = 1'b1; brake = 1'b1;
      settle(); check("R8 brake ignored in dual mode", 4'b0110);
      @(negedge clk); brake = 1'b0;
   endtask

   task automatic t_uv();
      hb_set(1, 1, 1, 1, 1);
      @(negedge clk); uv_flag = 1'b1;
      @(negedge clk); check("R9 uv one edge full bridge", 4'b0000);
      @(negedge clk); uv_flag = 1'b0; mode_hb = 1'b0; dir_ina = 1'b1; slow_dec = 1'b1;
      settle(); check("R9 dual before uv", 4'b1010);
      @(negedge clk); uv_flag = 1'b1;
      settle(); check("R9 uv dual", 4'b0000);
      @(negedge clk); uv_flag = 1'b0;
   endtask

   task automatic t_oc();
      hb_set(1, 1, 0, 1, 1);
      @(negedge clk); oc_b = 1'b1;
      settle(); check("R10 oc over brake full bridge", 4'b0000);
      @(negedge clk); oc_b = 1'b0; brake = 1'b0; oc_a = 1'b1;
      settle(); check("R10 oc_a full bridge", 4'b0000);
      @(negedge clk); mode_hb = 1'b0; dir_ina = 1'b1; slow_dec = 1'b0; pwm_enb = 1'b1;
      settle(); check("R10 oc_a dual hits A only", 4'b0001);
      @(negedge clk); oc_a = 1'b0; oc_b = 1'b1;
      settle(); check("R10 oc_b dual hits B only", 4'b1000);
      @(negedge clk); oc_b = 1'b0;
   endtask

   task automatic t_deadtime();
      int gap = 0;
      @(negedge clk);
      mode_hb = 1'b0; en_ena = 1'b1; pwm_enb = 1'b0; dir_ina = 1'b1; brake = 1'b0;
      settle(); check("R12 leg A top on", 4'b1000);
      dir_ina = 1'b0;
      @(negedge clk);
      check("R12 top drops after one edge", 4'b0000);
      while (!gate_bot_a && gap < 50) begin
         gap++;
         @(negedge clk);
      end
      check_int("R12 both-off cycles", gap, DT + 1);
      check("R12 bottom on after gap", 4'b0100);
      check_int("R11 no shoot-through seen", shoot, 0);
   endtask

   initial begin
      t_reset();
      t_diag();
      t_pwm_antiphase();
      t_slow();
      t_brake();
      t_enable();
      t_legs();
      t_uv();
      t_oc();
      t_deadtime();
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule